// File: doc/BRIEF.md
# Separable 8x8 Forward DCT Engine

This block turns one 8x8 tile of image samples into its 64 forward two-dimensional discrete cosine transform coefficients. Samples enter one per handshake as bytes in row-major order; an enable input chooses whether each byte is a pixel to be centred on zero (subtract 128) or an already signed two's complement value. A row engine runs an 8-point transform over each row as the row streams in and writes the results into a transpose store. A column engine then reads the store one column at a time and emits the normalised coefficients, again row-major, through a valid/ready output.

The transpose store has two banks. While the column engine drains one tile, the row engine fills the other, so a following tile is accepted without waiting. The input stalls only when both banks hold tiles that have not yet been handed to the output. All arithmetic is fixed point with cosine constants in Q1.14 and 32-bit intermediate sums, so the coefficients are defined exactly by the rules below.

Top module: `dct2d_8x8`

## Requirements
- R1: After reset `in_ready_o` is 1 and `out_valid_o` is 0.
- R2: With `level_shift_en_i` = 1 on a handshake, the sample value is the byte read as unsigned minus 128 (byte 0x80 gives 0, 0xFF gives 127).
- R3: With `level_shift_en_i` = 0 on a handshake, the byte is read as two's complement and sign-extended (0x80 gives -128, 0x7F gives 127).
- R4: Sample k of a tile (k = 0..63) sits at row k/8, column k%8. With C(f,i) = round(16384*cos(pi*(2i+1)*f/16)), the row result is t(r,f) = floor((sum over i of x(r,i)*C(f,i) + 8192) / 16384).
- R5: The column result is c(u,v) = floor((sum over r of t(r,v)*C(u,r) + 8192) / 16384) and the coefficient is floor((c(u,v)*K + 8192) / 16384), where K is 2048 when u = v = 0, 2896 when exactly one of u, v is 0, and 4096 otherwise.
- R6: Coefficients leave in row-major order: output n of a tile (n = 0..63) carries vertical frequency u = n/8 and horizontal frequency v = n%8; output 0 is the DC term, two's complement on `out_data_o`.
- R7: `out_last_o` is 1 exactly with the 64th coefficient of each tile and only while `out_valid_o` is 1.
- R8: While `out_valid_o` is 1 and `out_ready_i` is 0, the next cycle still shows `out_valid_o` = 1 with `out_data_o` and `out_last_o` unchanged.
- R9: Once a whole tile has been taken, `in_ready_o` stays 1 so a second tile can be taken while the first waits on the output; with both tiles complete and neither output started beyond its first coefficient, `in_ready_o` is 0; with no complete tile pending, `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| level_shift_en_i | input | 1 | 1: subtract 128 from the unsigned byte; 0: byte is signed |
| in_valid_i | input | 1 | Input sample valid |
| in_data_i | input | 8 | Input sample byte |
| in_ready_o | output | 1 | Input can take a sample |
| out_valid_o | output | 1 | Coefficient valid |
| out_ready_i | input | 1 | Consumer takes the coefficient |
| out_data_o | output | 16 | Signed coefficient |
| out_last_o | output | 1 | Last coefficient of the tile |

## Verification
The assertions assume the consumer never sees a coefficient it did not take and that tiles arrive whole, so their per-tile counters of taken samples and taken coefficients stay aligned with the design's own row and column positions. The stimulus always sends complete 64-sample tiles, holds `in_valid_i` and the byte steady until taken, and changes `out_ready_i` only between clock edges, with patterns of always ready, pseudo-random ready and held low. The held-low pattern is what stacks two tiles in the transpose store and drives the input stall.

// File: rtl/dct2d_pkg.sv
package dct2d_pkg;
  localparam int N      = 8;
  localparam int IDX_W  = $clog2(N);
  localparam int CNT_W  = 2 * IDX_W;
  localparam int IN_W   = 8;
  localparam int MID_W  = 16;
  localparam int ACC_W  = 32;
  localparam int FRAC   = 14;
  localparam int NBANK  = 2;

  typedef logic signed [MID_W-1:0] mid_t;
  typedef logic signed [ACC_W-1:0] acc_t;
  typedef logic signed [15:0]      q14_t;

  // cos(k*pi/16) in Q1.14, k = 0..7
  function automatic q14_t base_cos(input logic [2:0] k);
    case (k)
      3'd0:    return 16'sd16384;
      3'd1:    return 16'sd16069;
      3'd2:    return 16'sd15137;
      3'd3:    return 16'sd13623;
      3'd4:    return 16'sd11585;
      3'd5:    return 16'sd9102;
      3'd6:    return 16'sd6270;
      default: return 16'sd3196;
    endcase
  endfunction

  // basis term for frequency f, sample i: cos(pi*(2i+1)*f/16)
  function automatic q14_t cos_coef(input logic [IDX_W-1:0] f, input logic [IDX_W-1:0] i);
    logic [4:0] k;
    logic [4:0] m;
    k = {1'b0, i, 1'b1} * {2'b00, f};
    m = (k > 5'd16) ? 5'd0 - k : k;
    if (m == 5'd8)      return 16'sd0;
    else if (m < 5'd8)  return base_cos(m[2:0]);
    else                return -base_cos(3'(5'd16 - m));
  endfunction

  function automatic q14_t norm_k(input logic [IDX_W-1:0] u, input logic [IDX_W-1:0] v);
    if (u == '0 && v == '0)      return 16'sd2048;
    else if (u == '0 || v == '0) return 16'sd2896;
    else                         return 16'sd4096;
  endfunction

  function automatic mid_t round_q14(input acc_t a);
    acc_t r;
    r = (a + acc_t'(1 <<< (FRAC - 1))) >>> FRAC;
    return r[MID_W-1:0];
  endfunction
endpackage

// File: rtl/dct2d_row_pass.sv
module dct2d_row_pass
  import dct2d_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [IN_W-1:0]  in_data_i,
  input  logic             level_shift_en_i,
  input  logic             space_i,
  output logic             in_ready_o,
  output logic             row_we_o,
  output logic [IDX_W-1:0] row_idx_o,
  output mid_t             row_data_o [N],
  output logic             blk_done_o
);
  logic [IDX_W-1:0] col_q, row_q;
  acc_t acc_q [N];
  acc_t acc_d [N];
  mid_t x;
  logic take;

  assign in_ready_o = space_i;
  assign take       = in_valid_i & space_i;

  always_comb begin
    if (level_shift_en_i) x = mid_t'({{(MID_W-IN_W){1'b0}}, in_data_i}) - mid_t'(16'sd128);
    else                  x = mid_t'({{(MID_W-IN_W){in_data_i[IN_W-1]}}, in_data_i});
  end

  for (genvar v = 0; v < N; v++) begin : g_freq
    assign acc_d[v]      = acc_q[v] + acc_t'(x) * acc_t'(cos_coef(IDX_W'(v), col_q));
    assign row_data_o[v] = round_q14(acc_d[v]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
      for (int v = 0; v < N; v++) acc_q[v] <= '0;
    end else if (take) begin
      col_q <= col_q + 1'b1;
      if (col_q == IDX_W'(N - 1)) begin
        row_q <= row_q + 1'b1;
        for (int v = 0; v < N; v++) acc_q[v] <= '0;
      end else begin
        for (int v = 0; v < N; v++) acc_q[v] <= acc_d[v];
      end
    end
  end

  assign row_we_o   = take && (col_q == IDX_W'(N - 1));
  assign row_idx_o  = row_q;
  assign blk_done_o = row_we_o && (row_q == IDX_W'(N - 1));
endmodule

// File: rtl/dct2d_tbuf.sv
module dct2d_tbuf
  import dct2d_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] row_i,
  input  mid_t             data_i [N],
  input  logic             blk_done_i,
  input  logic [IDX_W-1:0] col_i,
  output mid_t             col_o [N],
  output logic             rd_avail_o,
  input  logic             release_i,
  output logic             wr_space_o
);
  mid_t mem_q [NBANK][N][N];
  logic [NBANK-1:0] full_q;
  logic wr_sel_q, rd_sel_q;

  always_ff @(posedge clk_i) begin
    if (we_i)
      for (int c = 0; c < N; c++) mem_q[wr_sel_q][row_i][c] <= data_i[c];
  end

  // fill and drain never target the same bank in one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q   <= '0;
      wr_sel_q <= 1'b0;
      rd_sel_q <= 1'b0;
    end else begin
      if (blk_done_i) begin
        full_q[wr_sel_q] <= 1'b1;
        wr_sel_q         <= ~wr_sel_q;
      end
      if (release_i) begin
        full_q[rd_sel_q] <= 1'b0;
        rd_sel_q         <= ~rd_sel_q;
      end
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_col
    assign col_o[r] = mem_q[rd_sel_q][r][col_i];
  end

  assign rd_avail_o = full_q[rd_sel_q];
  assign wr_space_o = ~full_q[wr_sel_q];
endmodule

// File: rtl/dct2d_col_pass.sv
module dct2d_col_pass
  import dct2d_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             avail_i,
  input  mid_t             col_i [N],
  output logic [IDX_W-1:0] col_sel_o,
  output logic             release_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output mid_t             out_data_o,
  output logic             out_last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] u, v;
  logic load;
  acc_t sum, scaled;
  mid_t cval, coef;

  assign u         = cnt_q[CNT_W-1:IDX_W];
  assign v         = cnt_q[IDX_W-1:0];
  assign col_sel_o = v;
  assign load      = avail_i && (!out_valid_o || out_ready_i);
  assign release_o = load && (cnt_q == '1);

  always_comb begin
    sum = '0;
    for (int r = 0; r < N; r++)
      sum = sum + acc_t'(col_i[r]) * acc_t'(cos_coef(u, IDX_W'(r)));
    cval   = round_q14(sum);
    scaled = acc_t'(cval) * acc_t'(norm_k(u, v));
    coef   = round_q14(scaled);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_last_o  <= 1'b0;
    end else if (load) begin
      cnt_q       <= cnt_q + 1'b1;
      out_valid_o <= 1'b1;
      out_data_o  <= coef;
      out_last_o  <= (cnt_q == '1);
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/dct2d_8x8.sv
module dct2d_8x8
  import dct2d_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        level_shift_en_i,
  input  logic        in_valid_i,
  input  logic [7:0]  in_data_i,
  output logic        in_ready_o,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output logic [15:0] out_data_o,
  output logic        out_last_o
);
  logic             row_we, blk_done, rd_avail, rel, wr_space;
  logic [IDX_W-1:0] row_idx, col_sel;
  mid_t             row_data [N];
  mid_t             col_data [N];
  mid_t             coef;

  dct2d_row_pass u_row (
    .clk_i, .rst_ni,
    .in_valid_i, .in_data_i, .level_shift_en_i,
    .space_i    (wr_space),
    .in_ready_o,
    .row_we_o   (row_we),
    .row_idx_o  (row_idx),
    .row_data_o (row_data),
    .blk_done_o (blk_done)
  );

  dct2d_tbuf u_tbuf (
    .clk_i, .rst_ni,
    .we_i       (row_we),
    .row_i      (row_idx),
    .data_i     (row_data),
    .blk_done_i (blk_done),
    .col_i      (col_sel),
    .col_o      (col_data),
    .rd_avail_o (rd_avail),
    .release_i  (rel),
    .wr_space_o (wr_space)
  );

  dct2d_col_pass u_col (
    .clk_i, .rst_ni,
    .avail_i    (rd_avail),
    .col_i      (col_data),
    .col_sel_o  (col_sel),
    .release_o  (rel),
    .out_valid_o,
    .out_ready_i,
    .out_data_o (coef),
    .out_last_o
  );

  assign out_data_o = coef;
endmodule

// File: rtl/dct2d_chk.sv
module dct2d_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [15:0] out_data_o,
  input logic        out_last_o
);
  logic       first_q;
  logic [5:0] in_cnt_q, out_cnt_q;
  int         pend_q;
  logic       in_hs, out_hs;

  assign in_hs  = in_valid_i && in_ready_o;
  assign out_hs = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q   <= 1'b1;
      in_cnt_q  <= '0;
      out_cnt_q <= '0;
      pend_q    <= 0;
    end else begin
      first_q <= 1'b0;
      if (in_hs)  in_cnt_q  <= in_cnt_q + 1'b1;
      if (out_hs) out_cnt_q <= out_cnt_q + 1'b1;
      pend_q <= pend_q + int'(in_hs && in_cnt_q == 6'd63) - int'(out_hs && out_last_o);
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_q |-> (in_ready_o && !out_valid_o));

  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));

  // R7
  last_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);

  // R7
  last_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_hs |-> (out_last_o == (out_cnt_q == 6'd63)));

  // R9
  idle_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == 0) |-> in_ready_o);
endmodule

bind dct2d_8x8 dct2d_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_last_o  (out_last_o)
);

// File: tb/dct2d_8x8_bench.sv
module dct2d_8x8_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lvl;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic        out_last;

  always #2 clk = ~clk;

  dct2d_8x8 u_dct2d_8x8 (
    .clk_i(clk), .rst_ni(rst_n), .level_shift_en_i(lvl),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_data_o(out_data), .out_last_o(out_last)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  int    exp_q[$];
  int    exp_idx = 0;
  int    rmode = 0;
  string cur_tag = "R6";
  bit    done = 0;
  logic [15:0] lfsr = 16'hACE1;
  int    blk [64];

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int q14_cos(input int f, input int i);
    real c;
    c = $cos(3.14159265358979323846 * real'(2 * i + 1) * real'(f) / 16.0) * 16384.0;
    if (c >= 0.0) return $rtoi(c + 0.5);
    else          return -$rtoi(-c + 0.5);
  endfunction

  function automatic int rnd14(input longint a);
    longint r;
    r = (a + 64'sd8192) >>> 14;
    return int'(r);
  endfunction

  task automatic model(input bit ls);
    int x [64];
    int t [64];
    int c, k, s2;
    longint a;
    s2 = $rtoi(1.41421356237309504880 / 8.0 * 16384.0 + 0.5);
    for (int n = 0; n < 64; n++) begin
      c = blk[n] & 255;
      x[n] = ls ? c - 128 : (c >= 128 ? c - 256 : c);
    end
    for (int r = 0; r < 8; r++)
      for (int f = 0; f < 8; f++) begin
        a = 0;
        for (int i = 0; i < 8; i++) a += longint'(x[r*8+i]) * q14_cos(f, i);
        t[r*8+f] = rnd14(a);
      end
    for (int u = 0; u < 8; u++)
      for (int v = 0; v < 8; v++) begin
        a = 0;
        for (int r = 0; r < 8; r++) a += longint'(t[r*8+v]) * q14_cos(u, r);
        c = rnd14(a);
        k = (u == 0 && v == 0) ? 2048 : ((u == 0 || v == 0) ? s2 : 4096);
        exp_q.push_back(rnd14(longint'(c) * k));
      end
  endtask

  task automatic send(input bit ls);
    model(ls);
    for (int n = 0; n < 64; n++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = blk[n][7:0];
      lvl      = ls;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // output side: drive ready, compare every taken coefficient, check holds
  logic        pv = 1'b0, pr = 1'b0, pl = 1'b0;
  logic [15:0] pd = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr) begin
        check("R8 valid held", int'(out_valid), 1);
        check("R8 data held", int'(out_data), int'(pd));
        check("R8 last held", int'(out_last), int'(pl));
      end
      case (rmode)
        0: out_ready = 1'b1;
        1: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          out_ready = lfsr[0];
        end
        default: out_ready = 1'b0;
      endcase
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check("R6 unexpected coefficient", 1, 0);
        else begin
          check({cur_tag, " coefficient"}, int'($signed(out_data)), exp_q.pop_front());
          check("R7 last flag", int'(out_last), int'(exp_idx == 63));
          exp_idx = (exp_idx + 1) % 64;
        end
      end
      pv = out_valid; pr = out_ready; pd = out_data; pl = out_last;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; lvl = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 in_ready after reset", int'(in_ready), 1);
    check("R1 out_valid after reset", int'(out_valid), 0);

    // R2: 0x80 with shift on is zero everywhere
    cur_tag = "R2";
    for (int n = 0; n < 64; n++) blk[n] = 128;
    send(1'b1); drain();

    // R3: same bytes read as signed give DC -1024
    cur_tag = "R3";
    send(1'b0); drain();

    // R4 R5 R6: irregular content
    cur_tag = "R4 R5 R6";
    for (int n = 0; n < 64; n++) blk[n] = (n * 53 + 17 * (n / 8) * (n / 8) + 5) & 255;
    send(1'b1); drain();

    // R3 R5: signed extremes in a checkerboard, random back-pressure
    cur_tag = "R3 R5";
    rmode = 1;
    for (int n = 0; n < 64; n++) blk[n] = (((n / 8) + (n % 8)) % 2) ? 127 : 128;
    send(1'b0); drain();

    // R8: ramp through the sign boundary under back-pressure
    cur_tag = "R8 R4";
    for (int n = 0; n < 64; n++) blk[n] = (n * 4 + 3) & 255;
    send(1'b0); drain();

    // R9: two tiles stacked while the output is held
    cur_tag = "R9";
    rmode = 2;
    for (int n = 0; n < 64; n++) blk[n] = (255 - n * 3) & 255;
    send(1'b1);
    repeat (2) @(negedge clk);
    check("R9 ready after first tile", int'(in_ready), 1);
    for (int n = 0; n < 64; n++) blk[n] = (n * n + 7) & 255;
    send(1'b1);
    repeat (3) @(negedge clk);
    check("R9 stall with both banks full", int'(in_ready), 0);
    rmode = 0;
    drain();
    check("R9 ready after drain", int'(in_ready), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired, actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule